// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous DRAM. It takes the memory from power-on to a usable state. Reset puts it in a holding state: clock enable and the data mask are held high, and only no-operation commands go out. It then counts a stabilization wait that is set in microseconds and converted to clock cycles from the clock frequency parameter. After the wait it closes both banks with a precharge-all. It then issues the auto-refresh cycles and programs the mode register from the configuration inputs. A parameter sets which of these two steps comes first.

Every command is followed by a parameterized number of no-operation cycles, so the memory's precharge, refresh-cycle and mode-load timing is met before the next command. After the last step a ready flag rises and stays high. From that point the bus belongs to the normal access scheduler. Asserting reset at any time drops the flag and restarts the whole bring-up.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and from its release until the precharge, the command bus carries no-operation, `init_done` is low, and `sd_cke` and `sd_dqm` are high. Command encoding on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`}: no-operation 0111, precharge 0010, auto-refresh 0001, mode load 0000.
- R2: The precharge appears on the cycle that follows exactly CLK_MHZ*WAIT_US no-operation cycles, counted from the first clock edge after reset release.
- R3: The precharge closes all banks: `sd_addr[10]` is 1, every other address bit is 0, and `sd_ba` is 0.
- R4: Exactly REFRESH_CNT auto-refresh commands are issued. The first command after the precharge comes T_RP cycles after it. Each refresh is followed T_RC cycles later by the next command or by the ready cycle, with no-operation in between.
- R5: The mode load drives `sd_addr[2:0]` = burst length, `sd_addr[3]` = burst type, `sd_addr[6:4]` = CAS latency and `sd_addr[9]` = write-burst mode. `sd_addr[8:7]`, `sd_addr[10]` and `sd_ba` are 0.
- R6: With MODE_FIRST=0 the order is precharge, refreshes, mode load. With MODE_FIRST=1 it is precharge, mode load, refreshes, and the first refresh follows the mode load by T_MRD cycles.
- R7: With MODE_FIRST=0, `init_done` rises on the cycle right after the mode load. With MODE_FIRST=1, it rises T_RC cycles after the last refresh.
- R8: Once `init_done` is high it stays high, and the command bus stays at no-operation, until the next reset.
- R9: A reset asserted part-way through the sequence forces no-operation and `init_done` low. After release, the whole sequence runs again from the wait, using the configuration inputs present at the new mode load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_burst_type | input | 1 | Burst type bit for the mode word |
| cfg_cas_lat | input | 3 | CAS latency code for the mode word |
| cfg_wr_single | input | 1 | Write-burst mode bit for the mode word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W (11) | Address bus; carries precharge-all flag and mode word |
| sd_ba | output | 1 | Bank select |
| sd_cke | output | 1 | Clock enable, held high |
| sd_dqm | output | 1 | Data mask, held high |
| init_done | output | 1 | Initialization complete |

## Verification
Two instances, one for each step order, are compared cycle by cycle against an expected command list. This catches a wait that is off by one cycle, which would move the precharge early or late. It also catches a gap counter that reloads badly, which would place a refresh or mode load at the wrong cycle. A mode word with a field shifted, or with a reserved bit set, is caught on the address compare. A ready flag that rises one cycle early or late, or rises before the trailing refresh gap in the mode-first order, is caught on the first cycle of `init_done`. A reset is injected in the middle of the refreshes. A design that kept its refresh count or its mode-done state across that reset would issue too few commands and end with a non-empty expected list.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // command code as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_GAP,
    ST_DONE
  } init_state_e;

  typedef enum logic [1:0] {
    STEP_REF,
    STEP_MRS,
    STEP_FIN
  } init_step_e;

endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int             CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_VAL;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // a load takes effect on the next edge (R2, R4)
  p_timer_load_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

  // an expired timer stays expired until reloaded (R2)
  p_timer_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);

endmodule

// File: rtl/init_step_pick.sv
module init_step_pick
  import sdram_init_pkg::*;
#(
  parameter bit MODE_FIRST = 1'b0
) (
  input  logic       ref_pending,
  input  logic       mode_pending,
  output init_step_e step
);

  generate
    if (MODE_FIRST) begin : g_mode_first
      always_comb begin
        if (mode_pending)     step = STEP_MRS;
        else if (ref_pending) step = STEP_REF;
        else                  step = STEP_FIN;
      end
    end else begin : g_refresh_first
      always_comb begin
        if (ref_pending)       step = STEP_REF;
        else if (mode_pending) step = STEP_MRS;
        else                   step = STEP_FIN;
      end
    end
  endgenerate

endmodule

// File: rtl/init_mode_word.sv
module init_mode_word #(
  parameter int ADDR_W = 11
) (
  input  logic [2:0]        burst_len,
  input  logic              burst_type,
  input  logic [2:0]        cas_lat,
  input  logic              wr_single,
  output logic [ADDR_W-1:0] word
);

  always_comb begin
    word      = '0;
    word[2:0] = burst_len;
    word[3]   = burst_type;
    word[6:4] = cas_lat;
    word[9]   = wr_single;
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int WAIT_US     = 200,
  parameter int ADDR_W      = 11,
  parameter int REFRESH_CNT = 2,
  parameter int T_RP        = 3,
  parameter int T_RC        = 8,
  parameter int T_MRD       = 2,
  parameter bit MODE_FIRST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_wr_single,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_ba,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic              init_done
);

  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int TMR_W    = $clog2(WAIT_CYC + 1);
  localparam int REF_W    = $clog2(REFRESH_CNT + 1);
  localparam logic [TMR_W-1:0] WAIT_LOAD = TMR_W'(WAIT_CYC - 1);
  localparam logic [TMR_W-1:0] RP_LOAD   = TMR_W'(T_RP - 2);
  localparam logic [TMR_W-1:0] RC_LOAD   = TMR_W'(T_RC - 2);
  localparam logic [TMR_W-1:0] MRD_LOAD  = TMR_W'(T_MRD - 2);

  init_state_e       state_q, state_d;
  logic [REF_W-1:0]  refs_left_q, refs_left_d;
  logic              mode_done_q, mode_done_d;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_expired;
  init_step_e        step;
  logic [ADDR_W-1:0] mode_word;

  sd_cmd_e           cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ba_q;
  logic              cke_q;
  logic              dqm_q;
  logic              done_q;

  init_timer #(
    .CNT_W   (TMR_W),
    .RST_VAL (WAIT_LOAD)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  // while issuing the mode load, the picker already sees it as done
  init_step_pick #(
    .MODE_FIRST (MODE_FIRST)
  ) u_pick (
    .ref_pending  (refs_left_q != '0),
    .mode_pending (!(mode_done_q || state_q == ST_MRS)),
    .step         (step)
  );

  init_mode_word #(
    .ADDR_W (ADDR_W)
  ) u_mode (
    .burst_len  (cfg_burst_len),
    .burst_type (cfg_burst_type),
    .cas_lat    (cfg_cas_lat),
    .wr_single  (cfg_wr_single),
    .word       (mode_word)
  );

  always_comb begin
    state_d     = state_q;
    refs_left_d = refs_left_q;
    mode_done_d = mode_done_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    unique case (state_q)
      ST_WAIT: begin
        if (tmr_expired) state_d = ST_PRE;
      end
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = RP_LOAD;
        state_d  = ST_GAP;
      end
      ST_REF: begin
        tmr_load    = 1'b1;
        tmr_val     = RC_LOAD;
        refs_left_d = refs_left_q - 1'b1;
        state_d     = ST_GAP;
      end
      ST_MRS: begin
        mode_done_d = 1'b1;
        if (step == STEP_FIN) begin
          state_d = ST_DONE;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = MRD_LOAD;
          state_d  = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tmr_expired) begin
          unique case (step)
            STEP_REF: state_d = ST_REF;
            STEP_MRS: state_d = ST_MRS;
            default:  state_d = ST_DONE;
          endcase
        end
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_WAIT;
      refs_left_q <= REF_W'(REFRESH_CNT);
      mode_done_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      refs_left_q <= refs_left_d;
      mode_done_q <= mode_done_d;
    end
  end

  // registered pin drivers: every output lags the state by one edge
  always_ff @(posedge clk) begin
    cke_q <= 1'b1;
    dqm_q <= 1'b1;
    ba_q  <= 1'b0;
    if (rst) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (state_q == ST_DONE);
      unique case (state_q)
        ST_PRE: begin
          cmd_q      <= CMD_PRE;
          addr_q     <= '0;
          addr_q[10] <= 1'b1;
        end
        ST_REF: begin
          cmd_q  <= CMD_REF;
          addr_q <= '0;
        end
        ST_MRS: begin
          cmd_q  <= CMD_MRS;
          addr_q <= mode_word;
        end
        default: begin
          cmd_q  <= CMD_NOP;
          addr_q <= '0;
        end
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_ba     = ba_q;
  assign sd_cke    = cke_q;
  assign sd_dqm    = dqm_q;
  assign init_done = done_q;

  // refresh commands seen on the pins since reset
  logic [REF_W:0] refs_seen_q;
  always_ff @(posedge clk) begin
    if (rst) refs_seen_q <= '0;
    else if (cmd_q == CMD_REF && refs_seen_q != '1) refs_seen_q <= refs_seen_q + 1'b1;
  end

  p_ref_count_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (refs_seen_q == (REF_W+1)'(REFRESH_CNT)));

  p_cmd_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));

  p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> (addr_q[10] && !ba_q));

  p_mode_clean_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_MRS) |-> (addr_q[8:7] == 2'b00 && !addr_q[10] && !ba_q));

  p_ready_after_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (!MODE_FIRST && $rose(init_done)) |-> ($past(cmd_q) == CMD_MRS));

  p_ready_after_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (MODE_FIRST && $rose(init_done)) |-> ($past(cmd_q) == CMD_NOP));

  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd_q == CMD_NOP));

  p_ready_hold_r8: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

endmodule

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;

  localparam int CLK_MHZ  = 125;
  localparam int WAIT_US  = 2;
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int REFS     = 3;
  localparam int T_RP     = 3;
  localparam int T_RC     = 7;
  localparam int T_MRD    = 2;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef struct packed {
    int          cyc;
    logic [3:0]  cmd;
    logic [10:0] addr;
    logic        ba;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_burst_len  = '0;
  logic       cfg_burst_type = 1'b0;
  logic [2:0] cfg_cas_lat    = '0;
  logic       cfg_wr_single  = 1'b0;

  logic a_cs, a_ras, a_cas, a_we, a_ba, a_cke, a_dqm, a_rdy;
  logic b_cs, b_ras, b_cas, b_we, b_ba, b_cke, b_dqm, b_rdy;
  logic [10:0] a_addr, b_addr;

  always #4 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .ADDR_W(11), .REFRESH_CNT(REFS),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .MODE_FIRST(1'b0)
  ) i_sdram_init_seq (
    .clk(clk), .rst(rst),
    .cfg_burst_len(cfg_burst_len), .cfg_burst_type(cfg_burst_type),
    .cfg_cas_lat(cfg_cas_lat), .cfg_wr_single(cfg_wr_single),
    .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we),
    .sd_addr(a_addr), .sd_ba(a_ba), .sd_cke(a_cke), .sd_dqm(a_dqm),
    .init_done(a_rdy)
  );

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .ADDR_W(11), .REFRESH_CNT(REFS),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .MODE_FIRST(1'b1)
  ) i_sdram_init_seq_mf (
    .clk(clk), .rst(rst),
    .cfg_burst_len(cfg_burst_len), .cfg_burst_type(cfg_burst_type),
    .cfg_cas_lat(cfg_cas_lat), .cfg_wr_single(cfg_wr_single),
    .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we),
    .sd_addr(b_addr), .sd_ba(b_ba), .sd_cke(b_cke), .sd_dqm(b_dqm),
    .init_done(b_rdy)
  );

  exp_t q_a[$];
  exp_t q_b[$];
  int   rdy_exp [2];
  bit   rdy_prev[2];
  int   n_vec = 0;
  int   n_err = 0;
  int   cyc   = 0;
  bit   mid_rst = 1'b0;
  logic rst_at_edge = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int v, input int c, input logic [3:0] cmd, input logic [10:0] addr);
    exp_t it;
    it.cyc = c; it.cmd = cmd; it.addr = addr; it.ba = 1'b0;
    if (v == 0) q_a.push_back(it);
    else        q_b.push_back(it);
  endtask

  // driver: expected command list for both step orders
  task automatic plan_all();
    logic [10:0] mw;
    int t;
    mw = {1'b0, cfg_wr_single, 2'b00, cfg_cas_lat, cfg_burst_type, cfg_burst_len};
    for (int v = 0; v < 2; v++) begin
      t = WAIT_CYC + 1;
      push(v, t, C_PRE, 11'h400);
      t += T_RP;
      if (v == 0) begin
        for (int k = 0; k < REFS; k++) begin
          push(v, t, C_REF, 11'h000);
          t += T_RC;
        end
        push(v, t, C_MRS, mw);
        rdy_exp[v] = t + 1;
      end else begin
        push(v, t, C_MRS, mw);
        t += T_MRD;
        for (int k = 0; k < REFS; k++) begin
          push(v, t, C_REF, 11'h000);
          t += T_RC;
        end
        rdy_exp[v] = t;
      end
    end
  endtask

  task automatic observe(input int v, input logic [3:0] cmd, input logic [10:0] addr,
                         input logic ba, input logic cke, input logic dqm, input logic rdy);
    exp_t it;
    bit   have;
    if (rst_at_edge) begin
      check(cmd == C_NOP && cke && dqm && !rdy, mid_rst ? "R9" : "R1",
            {cmd, cke, dqm, rdy}, {C_NOP, 3'b110});
      rdy_prev[v] = 1'b0;
    end else begin
      check(cke && dqm, "R1", {cke, dqm}, 2'b11);
      if (cmd != C_NOP) begin
        have = (v == 0) ? (q_a.size() > 0) : (q_b.size() > 0);
        if (!have) begin
          check(1'b0, "R6 unexpected command", cmd, C_NOP);
        end else begin
          it = (v == 0) ? q_a.pop_front() : q_b.pop_front();
          check(cmd == it.cmd, "R6 order", cmd, it.cmd);
          if (it.cmd == C_PRE)      check(cyc == it.cyc, "R2 precharge cycle", cyc, it.cyc);
          else if (it.cmd == C_REF) check(cyc == it.cyc, "R4 refresh cycle", cyc, it.cyc);
          else                      check(cyc == it.cyc, "R6 mode load cycle", cyc, it.cyc);
          if (it.cmd == C_MRS) check(addr == it.addr && ba == it.ba, "R5 mode word", {ba, addr}, {it.ba, it.addr});
          else                 check(addr == it.addr && ba == it.ba, "R3 address", {ba, addr}, {it.ba, it.addr});
        end
      end
      if (rdy && !rdy_prev[v]) check(cyc == rdy_exp[v], "R7 ready cycle", cyc, rdy_exp[v]);
      if (!rdy && rdy_prev[v]) check(1'b0, "R8 ready dropped", 0, 1);
      if (rdy) check(cmd == C_NOP, "R8 quiet after ready", cmd, C_NOP);
      rdy_prev[v] = rdy;
    end
  endtask

  always @(posedge clk) rst_at_edge <= rst;

  // monitor: compare pins against the scoreboard away from the edge
  always @(negedge clk) begin
    if (rst_at_edge) cyc = 0;
    else             cyc++;
    observe(0, {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba, a_cke, a_dqm, a_rdy);
    observe(1, {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba, b_cke, b_dqm, b_rdy);
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 20000) begin
      n_err++;
      $display("FAIL watchdog R7 ready not reached, actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  task automatic wait_ready();
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      if (a_rdy && b_rdy) break;
    end
    repeat (12) @(posedge clk);
  endtask

  task automatic end_run(input string req);
    #1;
    check(q_a.size() == 0, req, q_a.size(), 0);
    check(q_b.size() == 0, req, q_b.size(), 0);
    check(a_rdy && b_rdy, "R8 ready held", {a_rdy, b_rdy}, 2'b11);
  endtask

  initial begin
    // run 1: full bring-up with the first configuration
    cfg_burst_len = 3'b011; cfg_burst_type = 1'b1; cfg_cas_lat = 3'b010; cfg_wr_single = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    plan_all();
    rst = 1'b0;
    wait_ready();
    end_run("R4 leftover commands");

    // run 2: reset, then interrupt in the middle of the refreshes (R9)
    @(posedge clk); #1;
    mid_rst = 1'b1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    cfg_burst_len = 3'b111; cfg_burst_type = 1'b0; cfg_cas_lat = 3'b011; cfg_wr_single = 1'b1;
    q_a.delete(); q_b.delete();
    plan_all();
    rst = 1'b0;
    repeat (WAIT_CYC + T_RP + T_RC + 2) @(posedge clk);
    #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    cfg_burst_len = 3'b010; cfg_cas_lat = 3'b001;
    q_a.delete(); q_b.delete();
    plan_all();
    rst = 1'b0;
    wait_ready();
    end_run("R9 restart incomplete");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule